// File: doc/BRIEF.md
# USB Host Command and Interrupt Register Group

This block holds the software-visible command, interrupt and shared-memory-base registers of a USB host controller, together with the frame timer that marks each 1 ms frame. Software reaches it through a plain 32-bit register port: a word index, a write strobe, write data, and read data that is decoded combinationally from the index. The block drives a single level-sensitive interrupt request.

The frame timer counts strobes of a 12 MHz bit-rate enable. It advances only while the bus is marked operational. After every `FRAME_TICKS` strobes it raises a start-of-frame event, and that event latches the start-of-frame status flag. The interrupt line follows the status and enable registers at once. It can rise only while the master enable (enable bit 31) is set. Writing a 1 to the host-controller-reset bit (command bit 0) puts every register and the frame timer back to their reset state.

Top module: `usbh_irq_regs`

## Requirements
- R1: After reset, command (index 2) reads 0, status (index 3) reads 0, enable (indices 4 and 5) reads 0x8000_0000, base (index 6) reads 0, and irq is low.
- R2: A write to index 2 ORs the write data into the command register. Bits written as 1 become set and bits written as 0 are left as they were. For example, 0xC followed by 0x2 reads back as 0xE.
- R3: Command bits 7:6 are read-only and read 0. A write of 0xC0 to index 2 changes nothing.
- R4: A write to index 2 with bit 0 set is a soft reset. From the next cycle every register holds its R1 value, and the frame counter starts again from zero, so the next start-of-frame comes `FRAME_TICKS` strobes later.
- R5: Status is write-one-to-clear. A write to index 3 clears each status bit written as 1 and leaves alone each bit written as 0. The start-of-frame flag is status bit 2, which reads as 0x4.
- R6: A write to index 4 ORs the data into the enable store. A write to index 5 clears the written bits of that same store. Indices 4 and 5 both read the store.
- R7: irq is high exactly when enable bit 31 is set and (status AND enable) is nonzero. It follows register changes in the cycle after the write, with no further delay.
- R8: Only bits 31:8 of the base register (index 6) are writable. Writing 0x1234_5678 reads back as 0x1234_5600.
- R9: While bus_active is high, every `FRAME_TICKS`-th bit_tick strobe sets status bit 2. Strobes that arrive while bus_active is low do not advance the frame count.
- R10: When a start-of-frame event and a write of 1 to status bit 2 fall in the same cycle, bit 2 ends up set.
- R11: Indices that are not mapped (for example 0 and 7) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_active | input | 1 | Bus operational; the frame timer runs only while this is high |
| bit_tick | input | 1 | One-cycle enable strobe at the 12 MHz bit rate |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with `FRAME_TICKS` = 8 instead of 12,000. This puts several frame boundaries within a few dozen strobes. The bench places each strobe itself, so it can line a boundary up exactly with a status clear (R10), with a soft reset that interrupts a partly counted frame (R4), and with periods when the bus is inactive (R9). `ADDR_W` keeps its default of 4, which leaves unmapped indices on both sides of the mapped range.

// File: rtl/ush_pkg.sv
package ush_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned IDX_CMD   = 2;
  localparam int unsigned IDX_STS   = 3;
  localparam int unsigned IDX_ENSET = 4;
  localparam int unsigned IDX_ENCLR = 5;
  localparam int unsigned IDX_BASE  = 6;
  localparam int unsigned HCR_BIT   = 0;
  localparam int unsigned SOF_BIT   = 2;
  localparam int unsigned MIE_BIT   = 31;
  localparam logic [DW-1:0] SOC_MASK   = 32'h0000_00C0;
  localparam logic [DW-1:0] BASE_MASK  = 32'hFFFF_FF00;
  localparam logic [DW-1:0] EN_RESET   = 32'h8000_0000;

  // command write: OR-in, read-only overrun count masked away
  function automatic logic [DW-1:0] cmd_merge(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] wd);
    return cur | (wd & ~SOC_MASK);
  endfunction

  function automatic logic [DW-1:0] base_value(input logic [DW-1:0] wd);
    return wd & BASE_MASK;
  endfunction

  function automatic logic irq_level(input logic [DW-1:0] en,
                                     input logic [DW-1:0] sts);
    return en[MIE_BIT] & (|(en & sts));
  endfunction
endpackage

// File: rtl/ush_frame_timer.sv
module ush_frame_timer #(
  parameter int unsigned FRAME_TICKS = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic tick,
  output logic sof_evt
);
  localparam int unsigned CW = (FRAME_TICKS > 2) ? $clog2(FRAME_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          adv;
  logic          at_last;

  assign adv     = active & tick;
  assign at_last = (cnt_q == LAST);
  assign sof_evt = adv & at_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ush_reg_core.sv
module ush_reg_core
  import ush_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              sof_evt,
  output logic              soft_rst,
  output logic [DW-1:0]     cmd_q,
  output logic [DW-1:0]     sts_q,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     base_q,
  output logic [DW-1:0]     rdata
);
  logic wr_cmd, wr_sts, wr_set, wr_clr, wr_base;
  logic [DW-1:0] sts_d;

  assign wr_cmd  = wr && (addr == ADDR_W'(IDX_CMD));
  assign wr_sts  = wr && (addr == ADDR_W'(IDX_STS));
  assign wr_set  = wr && (addr == ADDR_W'(IDX_ENSET));
  assign wr_clr  = wr && (addr == ADDR_W'(IDX_ENCLR));
  assign wr_base = wr && (addr == ADDR_W'(IDX_BASE));

  assign soft_rst = wr_cmd & wdata[HCR_BIT];

  // status: clear-by-write first, then the frame event wins
  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_d & ~wdata;
    if (sof_evt) sts_d[SOF_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      en_q   <= EN_RESET;
      base_q <= '0;
    end else if (soft_rst) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      en_q   <= EN_RESET;
      base_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (wr_cmd)  cmd_q  <= cmd_merge(cmd_q, wdata);
      if (wr_set)  en_q   <= en_q | wdata;
      if (wr_clr)  en_q   <= en_q & ~wdata;
      if (wr_base) base_q <= base_value(wdata);
    end
  end

  always_comb begin
    unique case (int'(addr))
      IDX_CMD:              rdata = cmd_q;
      IDX_STS:              rdata = sts_q;
      IDX_ENSET, IDX_ENCLR: rdata = en_q;
      IDX_BASE:             rdata = base_q;
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/ush_irq_gate.sv
module ush_irq_gate
  import ush_pkg::*;
(
  input  logic [DW-1:0] en,
  input  logic [DW-1:0] sts,
  output logic          irq
);
  assign irq = irq_level(en, sts);
endmodule

// File: rtl/usbh_irq_regs.sv
module usbh_irq_regs
  import ush_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned FRAME_TICKS = 12000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_active,
  input  logic              bit_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  // named internal events, visible to the bound checker
  logic          sof_evt;
  logic          soft_rst;
  logic [DW-1:0] cmd_q, sts_q, en_q, base_q;

  ush_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (soft_rst),
    .active  (bus_active),
    .tick    (bit_tick),
    .sof_evt (sof_evt)
  );

  ush_reg_core #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .sof_evt  (sof_evt),
    .soft_rst (soft_rst),
    .cmd_q    (cmd_q),
    .sts_q    (sts_q),
    .en_q     (en_q),
    .base_q   (base_q),
    .rdata    (reg_rdata)
  );

  ush_irq_gate u_gate (
    .en  (en_q),
    .sts (sts_q),
    .irq (irq)
  );
endmodule

// File: rtl/usbh_irq_regs_chk.sv
module usbh_irq_regs_chk
  import ush_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic              irq,
  input logic              sof_evt,
  input logic              soft_rst,
  input logic [31:0]       cmd_q,
  input logic [31:0]       sts_q,
  input logic [31:0]       en_q,
  input logic [31:0]       base_q
);
  logic clr_sof;
  assign clr_sof = reg_wr && (reg_addr == ADDR_W'(IDX_STS)) && reg_wdata[SOF_BIT];

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q[MIE_BIT]);  // R7

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_q & sts_q) != 0));  // R7

  AST_CMD_BITS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((cmd_q & $past(cmd_q)) == $past(cmd_q)));  // R2

  AST_SOC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & SOC_MASK) == 0);  // R3

  AST_SOFT_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cmd_q == 0 && sts_q == 0 && en_q == EN_RESET && base_q == 0));  // R4

  AST_SOF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sof && !sof_evt) |=> !sts_q[SOF_BIT]);  // R5

  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[7:0] == 8'h00);  // R8

  AST_SOF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> sts_q[SOF_BIT]);  // R9

  AST_SOF_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_evt && clr_sof) |=> sts_q[SOF_BIT]);  // R10
endmodule

bind usbh_irq_regs usbh_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .sof_evt   (sof_evt),
  .soft_rst  (soft_rst),
  .cmd_q     (cmd_q),
  .sts_q     (sts_q),
  .en_q      (en_q),
  .base_q    (base_q)
);

// File: tb/tb_usbh_irq_regs.sv
`timescale 1ns/1ps
module tb_usbh_irq_regs;
  localparam int unsigned AW = 4;
  localparam int unsigned FT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_active = 1'b0;
  logic          bit_tick = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  usbh_irq_regs #(.ADDR_W(AW), .FRAME_TICKS(FT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .bit_tick(bit_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp_data;
    logic        exp_irq;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   failures = 0;
  logic rd_req = 1'b0;
  bit   done = 1'b0;

  // monitor: pops one expected item per read and compares
  always @(negedge clk) begin
    if (rd_req) begin
      exp_t it;
      if (expq.size() == 0) begin
        checks++; failures++;
        $display("FAIL monitor: read without expected item");
      end else begin
        it = expq.pop_front();
        checks++;
        if (reg_rdata !== it.exp_data || irq !== it.exp_irq) begin
          failures++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.tag, reg_rdata, irq, it.exp_data, it.exp_irq);
        end
      end
    end
  end

  task automatic rd(input int idx, input logic [31:0] e, input logic ei, input string tag);
    exp_t it;
    it.exp_data = e; it.exp_irq = ei; it.tag = tag;
    @(posedge clk); #1;
    expq.push_back(it);
    reg_addr = AW'(idx);
    rd_req = 1'b1;
    @(negedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = AW'(idx); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      bit_tick = 1'b1;
    end
    @(posedge clk); #1;
    bit_tick = 1'b0;
  endtask

  task automatic tick_with_clear();
    @(posedge clk); #1;
    reg_addr = AW'(3); reg_wdata = 32'h4; reg_wr = 1'b1; bit_tick = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(2, 32'h0, 1'b0, "R1 cmd");
    rd(3, 32'h0, 1'b0, "R1 status");
    rd(4, 32'h8000_0000, 1'b0, "R1 enable idx4");
    rd(5, 32'h8000_0000, 1'b0, "R1 enable idx5");
    rd(6, 32'h0, 1'b0, "R1 base");

    // R11 unmapped
    rd(0, 32'h0, 1'b0, "R11 idx0");
    rd(7, 32'h0, 1'b0, "R11 idx7");

    // R2 OR semantics, R3 overrun count read-only
    wr(2, 32'h0000_000C);
    rd(2, 32'h0000_000C, 1'b0, "R2 first set");
    wr(2, 32'h0000_0002);
    rd(2, 32'h0000_000E, 1'b0, "R2 OR merge");
    wr(2, 32'h0000_0000);
    rd(2, 32'h0000_000E, 1'b0, "R2 zero write keeps");
    wr(2, 32'h0000_00C0);
    rd(2, 32'h0000_000E, 1'b0, "R3 overrun bits ignored");

    // R8 base mask
    wr(6, 32'h1234_5678);
    rd(6, 32'h1234_5600, 1'b0, "R8 base mask");

    // R6 enable set/clear
    wr(4, 32'h0000_0004);
    rd(4, 32'h8000_0004, 1'b0, "R6 set idx4");
    rd(5, 32'h8000_0004, 1'b0, "R6 set read idx5");
    wr(5, 32'h8000_0000);
    rd(4, 32'h0000_0004, 1'b0, "R6 clear master");

    // R9 frame timer: inactive bus ignores strobes
    ticks(20);
    rd(3, 32'h0, 1'b0, "R9 inactive bus");
    bus_active = 1'b1;
    ticks(FT - 1);
    rd(3, 32'h0, 1'b0, "R9 before boundary");
    ticks(1);
    rd(3, 32'h4, 1'b0, "R9 boundary / R7 master off");
    wr(4, 32'h8000_0000);
    rd(4, 32'h8000_0004, 1'b1, "R7 master on raises irq");

    // R5 write-one-to-clear
    wr(3, 32'hFFFF_FFFB);
    rd(3, 32'h4, 1'b1, "R5 zero bit keeps");
    wr(3, 32'h0000_0004);
    rd(3, 32'h0, 1'b0, "R5 one bit clears");

    // R10 event vs clear in same cycle
    ticks(FT - 1);
    rd(3, 32'h0, 1'b0, "R10 pre-collision");
    tick_with_clear();
    rd(3, 32'h4, 1'b1, "R10 event wins");

    // R7 per-source enable gating
    wr(5, 32'h0000_0004);
    rd(3, 32'h4, 1'b0, "R7 source disabled");
    wr(4, 32'h0000_0004);
    rd(3, 32'h4, 1'b1, "R7 source re-enabled");

    // R4 soft reset mid-frame
    ticks(3);
    wr(2, 32'h0000_0001);
    rd(2, 32'h0, 1'b0, "R4 cmd cleared");
    rd(3, 32'h0, 1'b0, "R4 status cleared");
    rd(4, 32'h8000_0000, 1'b0, "R4 enable reset");
    rd(6, 32'h0, 1'b0, "R4 base cleared");
    ticks(FT - 1);
    rd(3, 32'h0, 1'b0, "R4 timer restarted, not yet");
    ticks(1);
    rd(3, 32'h4, 1'b0, "R4 timer restarted, boundary");

    @(posedge clk); #1;
    if (expq.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: leftover=%0d expected=0", expq.size());
    end
    summary();
  end
endmodule